// File: doc/BRIEF.md
# Input Change Interrupt Generator

This block raises an interrupt request for a general-purpose I/O expander whose pins are grouped into byte-wide ports. Each pin value is brought through a synchroniser into the core clock domain. For every port the block keeps a latched copy of the pin values, which is the port's input register. When a pin set up as an input no longer matches its latched bit, the block enables a pull-down on a shared, active-low, open-drain interrupt line. The block never drives the line high.

The request clears in either of two ways. The pin can return to its latched value. Or the bus interface can read that port's input register: the read strobe copies the port's current synchronised pins into its latched register, so the mismatch goes away. Ports are independent, so a read of one port leaves a pending change on another port asserted. Pins set up as outputs are left out of the comparison.

During a short warm-up after reset, the latched registers follow the synchronised pins and the request is held off. As a result no interrupt fires just because the part has come out of reset.

Top module: `pin_change_irq`

## Requirements
- R1: After reset is released, `intPullDown` stays low for the first SYNC_STAGES+1 clock edges. Once those edges have passed, `inPortReg` equals the pin values held steady through reset, and `intPullDown` is low.
- R2: When a pin whose `dirIsInput` bit is 1 changes so that it differs from its bit in `inPortReg`, `intPullDown` goes high on the SYNC_STAGES+1-th rising edge after the change.
- R3: If that pin returns to its latched value, `intPullDown` goes low again after the same latency, provided no other mismatch is present.
- R4: A one-cycle pulse on `readStrobe[p]` loads the synchronised pin values into `inPortReg[p*PORT_WIDTH +: PORT_WIDTH]` for every bit of port p, including output bits. If no mismatch remains, `intPullDown` falls on the following edge.
- R5: A pin whose `dirIsInput` bit is 0 never causes `intPullDown` to assert. When every direction bit is 0, `intPullDown` is low on the next edge.
- R6: A read of one port does not clear a mismatch pending on another port. `intPullDown` stays high until the other port itself is read or its pins return.
- R7: After warm-up, a port's slice of `inPortReg` holds its value in every cycle in which that port's `readStrobe` bit is low, whatever the pins do.
- R8: When a direction bit changes from 0 to 1 on a pin that already differs from its latched bit, `intPullDown` goes high on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinRaw | input | NUM_PORTS*PORT_WIDTH | Asynchronous pin levels; port p occupies bits [p*PORT_WIDTH +: PORT_WIDTH] |
| dirIsInput | input | NUM_PORTS*PORT_WIDTH | Per-pin direction; 1 = input, 0 = output |
| readStrobe | input | NUM_PORTS | One-cycle pulse per port when its input register is read |
| inPortReg | output | NUM_PORTS*PORT_WIDTH | Latched input register contents, same bit layout as pinRaw |
| intPullDown | output | 1 | 1 = pull the interrupt line low |

## Verification
The bench uses the default build: two ports of eight pins and a two-stage synchroniser. The warm-up therefore lasts three edges, and the pin-to-request latency is three edges, which the bench samples on exact cycles. With two ports, the bench can test cross-port independence: it reads one port while the other holds a pending change, and it flips direction bits on a port while its pins differ from the latch.

// File: rtl/icg_pkg.sv
package icg_pkg;
  localparam int MAX_PORTS = 8;

  typedef struct packed {
    logic                 loadAll;
    logic [MAX_PORTS-1:0] loadPort;
    logic                 holdOff;
  } icgStrobes_t;
endpackage

// File: rtl/icg_sync.sv
module icg_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else begin
      stageQ[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dOut = stageQ[STAGES-1];
endmodule

// File: rtl/icg_control.sv
module icg_control
  import icg_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] readStrobe,
  output icgStrobes_t          strobes
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(WARM + 1);

  logic [CNT_W-1:0] warmCnt;
  logic             warming;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= CNT_W'(WARM);
    else if (warmCnt != '0) warmCnt <= warmCnt - 1'b1;
  end

  assign warming = (warmCnt != '0);

  always_comb begin
    strobes          = '0;
    strobes.loadAll  = warming;
    strobes.holdOff  = warming;
    strobes.loadPort[NUM_PORTS-1:0] = readStrobe;
  end
endmodule

// File: rtl/icg_datapath.sv
module icg_datapath
  import icg_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_WIDTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] pinRaw,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] dirIsInput,
  input  icgStrobes_t                     strobes,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] latched,
  output logic                            intPullDown
);
  localparam int PINS = NUM_PORTS * PORT_WIDTH;

  logic [PINS-1:0]      syncPins;
  logic [PINS-1:0]      mismatch;
  logic [NUM_PORTS-1:0] portChanged;

  icg_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (pinRaw),
    .dOut(syncPins)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latched <= '0;
    else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobes.loadAll || strobes.loadPort[p])
          latched[p*PORT_WIDTH +: PORT_WIDTH] <= syncPins[p*PORT_WIDTH +: PORT_WIDTH];
      end
    end
  end

  assign mismatch = (syncPins ^ latched) & dirIsInput;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign portChanged[g] = |mismatch[g*PORT_WIDTH +: PORT_WIDTH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intPullDown <= 1'b0;
    else       intPullDown <= (|portChanged) && !strobes.holdOff;
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import icg_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_WIDTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] pinRaw,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] dirIsInput,
  input  logic [NUM_PORTS-1:0]            readStrobe,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] inPortReg,
  output logic                            intPullDown
);
  icgStrobes_t strobes;

  initial begin
    if (NUM_PORTS > MAX_PORTS || SYNC_STAGES < 2)
      $error("pin_change_irq: unsupported parameter values");
  end

  icg_control #(.NUM_PORTS(NUM_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .readStrobe(readStrobe),
    .strobes   (strobes)
  );

  icg_datapath #(
    .NUM_PORTS(NUM_PORTS), .PORT_WIDTH(PORT_WIDTH), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinRaw     (pinRaw),
    .dirIsInput (dirIsInput),
    .strobes    (strobes),
    .latched    (inPortReg),
    .intPullDown(intPullDown)
  );
endmodule

// File: rtl/pin_change_irq_checker.sv
module pin_change_irq_checker #(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_WIDTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [NUM_PORTS*PORT_WIDTH-1:0] dirIsInput,
  input logic [NUM_PORTS-1:0]            readStrobe,
  input logic [NUM_PORTS*PORT_WIDTH-1:0] inPortReg,
  input logic                            intPullDown
);
  localparam int WARM  = SYNC_STAGES + 1;
  localparam int CK_W  = $clog2(WARM + 2) + 1;

  logic [CK_W-1:0] ckCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckCnt <= '0;
    else if (ckCnt <= CK_W'(WARM)) ckCnt <= ckCnt + 1'b1;
  end

  assert_quiet_warmup_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ckCnt <= CK_W'(WARM)) |-> !intPullDown);

  assert_needs_input_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ckCnt > CK_W'(WARM) && intPullDown) |-> $past(|dirIsInput));

  assert_outputs_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dirIsInput == '0) |=> !intPullDown);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hold
    assert_hold_unread_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ckCnt >= CK_W'(WARM) && !readStrobe[p])
        |=> $stable(inPortReg[p*PORT_WIDTH +: PORT_WIDTH]));
  end
endmodule

bind pin_change_irq pin_change_irq_checker #(
  .NUM_PORTS(NUM_PORTS), .PORT_WIDTH(PORT_WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dirIsInput (dirIsInput),
  .readStrobe (readStrobe),
  .inPortReg  (inPortReg),
  .intPullDown(intPullDown)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int PW = 8;
  localparam int NV = 13;

  // {pins[16], dir[16], read[2], expPull[1], expReg[16]}
  localparam logic [50:0] VECS [NV] = '{
    {16'hA55A, 16'hFFFF, 2'b00, 1'b0, 16'hA55A},  // R1 baseline
    {16'hA55B, 16'hFFFF, 2'b00, 1'b1, 16'hA55A},  // R2
    {16'hA55A, 16'hFFFF, 2'b00, 1'b0, 16'hA55A},  // R3
    {16'hA55B, 16'hFFFF, 2'b01, 1'b0, 16'hA55B},  // R4
    {16'h255B, 16'hFFFF, 2'b01, 1'b1, 16'hA55B},  // R6
    {16'h255B, 16'hFFFF, 2'b10, 1'b0, 16'h255B},  // R4
    {16'h25A4, 16'hFF00, 2'b00, 1'b0, 16'h255B},  // R5 R7
    {16'h25A4, 16'hFF01, 2'b00, 1'b1, 16'h255B},  // R8
    {16'h25A4, 16'hFF00, 2'b00, 1'b0, 16'h255B},  // R5
    {16'h25A4, 16'hFF00, 2'b01, 1'b0, 16'h25A4},  // R4 output bits load
    {16'hDAA4, 16'h00FF, 2'b00, 1'b0, 16'h25A4},  // R5 R7
    {16'hDAA4, 16'hFFFF, 2'b00, 1'b1, 16'h25A4},  // R8
    {16'hDAA4, 16'hFFFF, 2'b11, 1'b0, 16'hDAA4}   // R4
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   pinRaw = 16'hA55A;
  logic [15:0]   dirIsInput = 16'hFFFF;
  logic [1:0]    readStrobe = 2'b00;
  logic [15:0]   inPortReg;
  logic          intPullDown;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.NUM_PORTS(NP), .PORT_WIDTH(PW), .SYNC_STAGES(2)) u_pin_change_irq (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .dirIsInput(dirIsInput),
    .readStrobe(readStrobe), .inPortReg(inPortReg), .intPullDown(intPullDown)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // reset state
    waitNeg(2);
    check(intPullDown == 1'b0, "R1 pull in reset", 16'(intPullDown), 16'h0);
    rstN = 1'b1;
    waitNeg(3);
    check(intPullDown == 1'b0, "R1 pull during warm-up", 16'(intPullDown), 16'h0);
    waitNeg(3);
    check(inPortReg == 16'hA55A, "R1 latched after warm-up", inPortReg, 16'hA55A);
    check(intPullDown == 1'b0, "R1 pull after warm-up", 16'(intPullDown), 16'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      pinRaw     = VECS[v][50:35];
      dirIsInput = VECS[v][34:19];
      waitNeg(4);
      if (VECS[v][18:17] != 2'b00) begin
        readStrobe = VECS[v][18:17];
        waitNeg(1);
        readStrobe = 2'b00;
        waitNeg(3);
      end
      check(intPullDown == VECS[v][16], $sformatf("vec%0d pull R2 R3 R4 R5 R6 R8", v),
            16'(intPullDown), 16'(VECS[v][16]));
      check(inPortReg == VECS[v][15:0], $sformatf("vec%0d reg R4 R7", v),
            inPortReg, VECS[v][15:0]);
    end

    // latency: state is pins DAA4 latched DAA4, all inputs
    pinRaw = 16'hDAA5;
    waitNeg(2);
    check(intPullDown == 1'b0, "R2 not before latency", 16'(intPullDown), 16'h0);
    waitNeg(1);
    check(intPullDown == 1'b1, "R2 exact latency", 16'(intPullDown), 16'h1);
    pinRaw = 16'hDAA4;
    waitNeg(2);
    check(intPullDown == 1'b1, "R3 still high before latency", 16'(intPullDown), 16'h1);
    waitNeg(1);
    check(intPullDown == 1'b0, "R3 exact latency", 16'(intPullDown), 16'h0);

    // read of port 1 leaves port 0 pending; read clears on the next edge
    pinRaw = 16'hDAA6;
    waitNeg(4);
    readStrobe = 2'b10;
    waitNeg(1);
    readStrobe = 2'b00;
    waitNeg(2);
    check(intPullDown == 1'b1, "R6 port1 read keeps port0 pending", 16'(intPullDown), 16'h1);
    check(inPortReg == 16'hDAA4, "R7 port0 unread holds", inPortReg, 16'hDAA4);
    readStrobe = 2'b01;
    waitNeg(1);
    readStrobe = 2'b00;
    check(inPortReg == 16'hDAA6, "R4 load on read edge", inPortReg, 16'hDAA6);
    waitNeg(1);
    check(intPullDown == 1'b0, "R4 clear one edge after read", 16'(intPullDown), 16'h0);

    // all outputs: toggling never interrupts
    dirIsInput = 16'h0000;
    pinRaw = 16'h1234;
    waitNeg(5);
    check(intPullDown == 1'b0, "R5 all outputs quiet", 16'(intPullDown), 16'h0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule